// File: doc/BRIEF.md
# Ranked Call Dispatcher

A front-panel controller for a shared attendant. Several stations each have a call button and an acknowledge input, both active low. A press is captured and held until that station's own acknowledge arrives. Out of everything pending, only one call is shown at a time: the one held by the most senior station. The choice appears both as a one-hot lamp vector and as a binary index with a valid flag.

Stations 0 and 1 form the top tier and share one rank. Stations 2, 3 and 4 follow in that order. When the attendant acknowledges the call on display, the next most senior pending call takes its place on the following clock edge. This repeats until nothing is left. A synchronous clear drops every held call at once.

Button and acknowledge inputs pass through a two-flop synchroniser before they reach the request latches. The display register is loaded from the latches one edge later. Debouncing and lamp drive are left to the surrounding logic.

Top module: `prio_call_dispatch`

## Requirements
- R1: At most one bit of `lamp` is high. `lamp_vld` is high exactly when one bit is lit, and `lamp_idx` then gives the position of that bit. When no bit is lit, `lamp_idx` is 0.
- R2: A station's call is latched when its `call_n` bit is sampled low. The call stays pending after the button is released, until that station is acknowledged or `clr` is applied.
- R3: A pending call at station 0 or station 1 is always displayed in preference to any pending call at stations 2 to 4.
- R4: Among stations 2 to 4, the lowest-numbered pending station is displayed.
- R5: When stations 0 and 1 are both pending, station 0 is shown, unless station 1 is already on display. Equal rank does not pre-empt, so a displayed station 1 stays on display until it is acknowledged.
- R6: A low `ack_n` bit clears only that station's latch. After that, the next most senior pending call is displayed.
- R7: An acknowledge for a station with no pending call leaves the display and all other pending calls unchanged.
- R8: If the synchronised acknowledge and call for a station are both active in the same cycle, the acknowledge wins and the latch is cleared. A call that is still held then re-latches one cycle later.
- R9: `clr` high at a rising edge clears every latch at that edge, and the display goes idle at the next edge.
- R10: While `rst_n` is low, the latches and synchronisers are cleared, `lamp` is 0, `lamp_vld` is 0 and `lamp_idx` is 0.
- R11: A change on `call_n` or `ack_n` reaches the display registers at the fourth rising edge after it is applied mid-cycle. Two edges are spent in the synchroniser, one in the latch and one in the display.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all pending calls, active high |
| call_n | input | NUM_STN | Call buttons, active low, bit i is station i |
| ack_n | input | NUM_STN | Per-station acknowledge, active low |
| lamp | output | NUM_STN | One-hot indicator of the displayed station |
| lamp_idx | output | IDX_W | Binary index of the displayed station |
| lamp_vld | output | 1 | A call is on display |

## Verification
A latch that drops or gains a bit cannot be read directly. It shows up at the ports only once every more senior call has been acknowledged. At that point the display either skips a station or shows one that was never called, one edge after the latch changes. A fault in the equal-rank hold rule appears as a switch from station 1 to station 0 four edges after station 0 is pressed. Because of this, the bench drains the queue completely after every directed scenario. It also keeps a cycle-accurate reference model in step with the design throughout a long random run, so that any divergence is caught in the cycle it happens.

// File: rtl/prio_call_dispatch.sv
module prio_call_dispatch #(
  parameter int NUM_STN     = 5,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_STN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NUM_STN-1:0] call_n,
  input  logic [NUM_STN-1:0] ack_n,
  output logic [NUM_STN-1:0] lamp,
  output logic [IDX_W-1:0]   lamp_idx,
  output logic               lamp_vld
);

  logic [NUM_STN-1:0] call_pipe [SYNC_STAGES];
  logic [NUM_STN-1:0] ack_pipe  [SYNC_STAGES];
  logic [NUM_STN-1:0] call_s, ack_s, pend;
  logic [NUM_STN-1:0] nxt_oh;
  logic [IDX_W-1:0]   nxt_idx;
  logic               nxt_vld;
  logic               hold_top2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        call_pipe[s] <= '0;
        ack_pipe[s]  <= '0;
      end
    end else begin
      call_pipe[0] <= ~call_n;
      ack_pipe[0]  <= ~ack_n;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        call_pipe[s] <= call_pipe[s-1];
        ack_pipe[s]  <= ack_pipe[s-1];
      end
    end
  end

  assign call_s = call_pipe[SYNC_STAGES-1];
  assign ack_s  = ack_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= '0;
    else if (clr) pend <= '0;
    else          pend <= (pend | call_s) & ~ack_s;
  end

  // equal rank at the top tier: a displayed station 1 is not displaced by station 0
  assign hold_top2 = lamp_vld && (lamp_idx == IDX_W'(1)) && pend[1];

  always_comb begin
    nxt_oh  = '0;
    nxt_idx = '0;
    nxt_vld = 1'b0;
    for (int i = NUM_STN-1; i >= 0; i--) begin
      if (pend[i]) begin
        nxt_oh  = '0;
        nxt_oh[i] = 1'b1;
        nxt_idx = IDX_W'(i);
        nxt_vld = 1'b1;
      end
    end
    if (hold_top2) begin
      nxt_oh  = '0;
      nxt_oh[1] = 1'b1;
      nxt_idx = IDX_W'(1);
      nxt_vld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lamp     <= '0;
      lamp_idx <= '0;
      lamp_vld <= 1'b0;
    end else begin
      lamp     <= nxt_oh;
      lamp_idx <= nxt_idx;
      lamp_vld <= nxt_vld;
    end
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lamp));
  a_r1_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_vld |-> lamp[lamp_idx]);
  a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !lamp_vld |-> (lamp == '0));
  a_r3_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] || pend[1]) |=> (lamp_vld && (lamp_idx < IDX_W'(2))));
  a_r4_lower_order: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend[0] && !pend[1] && pend[2]) |=> (lamp_idx == IDX_W'(2)));
  a_r5_equal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lamp_vld && lamp_idx == IDX_W'(1) && pend[1]) |=> (lamp_idx == IDX_W'(1)));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pend == '0));

  for (genvar g = 0; g < NUM_STN; g++) begin : g_chk
    a_r2_persist: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !ack_s[g] && !clr) |=> pend[g]);
    a_r8_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ack_s[g] |=> !pend[g]);
  end

endmodule

// File: tb/tb_prio_call_dispatch.sv
module tb_prio_call_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [N-1:0] call_n = '1;
  logic [N-1:0] ack_n = '1;
  logic [N-1:0] lamp;
  logic [IW-1:0] lamp_idx;
  logic lamp_vld;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_call_dispatch #(.NUM_STN(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .call_n(call_n), .ack_n(ack_n),
    .lamp(lamp), .lamp_idx(lamp_idx), .lamp_vld(lamp_vld));

  // reference model built from the requirements
  logic [N-1:0] m_c1, m_c2, m_a1, m_a2, m_pend;
  logic [IW-1:0] m_idx;
  logic m_vld;

  function automatic logic [IW:0] pick(logic [N-1:0] p, logic [IW-1:0] ci, logic cv);
    if (cv && ci == IW'(1) && p[1]) return {1'b1, IW'(1)};
    for (int i = 0; i < N; i++) if (p[i]) return {1'b1, IW'(i)};
    return '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c1 <= '0; m_c2 <= '0; m_a1 <= '0; m_a2 <= '0; m_pend <= '0;
      m_idx <= '0; m_vld <= 1'b0;
    end else begin
      m_c1 <= ~call_n; m_c2 <= m_c1;
      m_a1 <= ~ack_n;  m_a2 <= m_a1;
      for (int i = 0; i < N; i++)
        if (clr || m_a2[i]) m_pend[i] <= 1'b0;
        else if (m_c2[i])   m_pend[i] <= 1'b1;
      {m_vld, m_idx} <= pick(m_pend, m_idx, m_vld);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic show(string req, logic [N-1:0] exp_lamp);
    check(req, 32'(lamp), 32'(exp_lamp));
  endtask

  task automatic press(logic [N-1:0] m);
    call_n = ~m; tick(1); call_n = '1;
  endtask

  task automatic ack(int s);
    ack_n = '1; ack_n[s] = 1'b0; tick(1); ack_n = '1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    // R10 reset state
    show("R10 lamp", '0);
    check("R10 vld", 32'(lamp_vld), 0);
    check("R10 idx", 32'(lamp_idx), 0);
    rst_n = 1'b1;
    tick(2);

    // R11 latency and R3 top preemption over 2 and 4
    call_n = ~5'b10101; tick(1); call_n = '1;
    tick(2);
    show("R11 not yet", '0);
    tick(1);
    show("R3 top wins", 5'b00001);
    check("R1 idx", 32'(lamp_idx), 0);
    tick(6);
    show("R2 persists", 5'b00001);

    ack(0); tick(3);
    show("R6 next is 2", 5'b00100);
    check("R1 idx 2", 32'(lamp_idx), 2);
    ack(3); tick(5);
    show("R7 stray ack", 5'b00100);
    ack(2); tick(3);
    show("R4 then 4", 5'b10000);
    ack(4); tick(3);
    show("R6 drained", '0);
    check("R1 vld low", 32'(lamp_vld), 0);

    // R5 equal rank hold
    press(5'b00010); tick(4);
    show("R5 station1", 5'b00010);
    press(5'b00001); tick(5);
    show("R5 hold on 1", 5'b00010);
    ack(1); tick(3);
    show("R5 then 0", 5'b00001);
    ack(0); tick(3);
    show("R5 idle", '0);

    // R5 simultaneous tie and R9 clear
    press(5'b01011); tick(4);
    show("R5 tie to 0", 5'b00001);
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    show("R9 cleared", '0);
    tick(4);
    show("R9 stays clear", '0);

    // R8 ack wins over a held call
    call_n = ~5'b00100; tick(5);
    show("R8 lit", 5'b00100);
    ack(2); tick(3);
    show("R8 ack wins", '0);
    tick(1);
    show("R8 relatch", 5'b00100);
    call_n = '1; tick(2);
    ack(2); tick(4);
    show("R8 done", '0);

    // random run against the model
    for (int c = 0; c < 3000; c++) begin
      show("R4 model", m_vld ? (N'(1) << m_idx) : '0);
      check("R1 model idx", 32'(lamp_idx), 32'(m_idx));
      check("R1 model vld", 32'(lamp_vld), 32'(m_vld));
      for (int i = 0; i < N; i++) begin
        call_n[i] = ($urandom_range(7) != 0);
        ack_n[i]  = ($urandom_range(11) != 0);
      end
      clr = ($urandom_range(99) == 0);
      tick(1);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule